// File: doc/BRIEF.md
# Serial Storage Link Transmit Frame Sequencer

This block turns one payload into a complete frame on the transmit side of a serial storage link. Payload dwords arrive on a valid/ready stream that marks the final dword. The block sends one 32-bit slot per clock to the PHY, with a flag that marks each slot as either a control primitive or a data dword. In each slot it looks at the dword just received from the far end and decides what to send.

The block starts from IDLE and sends SYNC. When a payload is offered it requests the link (RDY, which repeats X_RDY) and waits for the receiver to grant it with R_RDY. It then opens the frame with one SOF slot (SOF state) and streams the payload (DATA state). Each payload dword is folded into a running CRC-32 and XORed with the next word of a 16-bit LFSR scrambler. After the final payload dword it sends the scrambled CRC, closes the frame with one EOF (EOF state) and repeats WTRM (WTRM state) until the receiver returns a verdict. The verdict is reported with a one-slot pulse, and the block goes back to IDLE.

During DATA, a HOLD from the receiver is answered with HOLDA and nothing advances. A payload source that is not ready is covered by sending HOLD. The transitions are:
- IDLE→RDY on an offered payload.
- RDY→SOF on R_RDY.
- SOF→DATA always.
- DATA→EOF after the CRC slot.
- EOF→WTRM always.
- WTRM→IDLE on R_OK or R_ERR.

Top module: `link_tx_framer`

## Requirements
- R1: Out of a frame (IDLE, including while rst_n is low) the block sends SYNC (0xB5B5957C, tx_isk=1) with pl_ready=0 and done_valid=0. Received dwords, including R_RDY (0x4A4A957C) and R_OK (0x3535B57C), have no effect there. pl_valid=1 in IDLE moves to RDY on the next slot without consuming the dword.
- R2: In RDY every slot carries X_RDY (0x5757B57C, tx_isk=1) until a slot in which rx_dword equals R_RDY. The next slot is SOF.
- R3: SOF (0x3737B57C, tx_isk=1) is sent for exactly one slot, followed by DATA. The SOF slot reloads the CRC seed and the scrambler seed.
- R4: In a DATA slot where rx_dword is not HOLD and pl_valid=1 before the last payload dword has been taken, pl_ready=1 and tx_dword = pl_data XOR the current scrambler word, with tx_isk=0.
- R5: In any DATA slot (payload or CRC) where rx_dword equals HOLD (0xD5D5AA7C), the block sends HOLDA (0x9595AA7C, tx_isk=1) with pl_ready=0. The CRC and the scrambler do not advance, so the held dword is sent unchanged in the next free slot.
- R6: In a DATA payload slot with no HOLD received and pl_valid=0, the block sends HOLD (0xD5D5AA7C, tx_isk=1) with pl_ready=0.
- R7: The DATA slot after the dword taken with pl_last=1 carries the CRC XOR the next scrambler word (tx_isk=0). The CRC is CRC-32 with polynomial 0x04C11DB7 and seed 0x52325032, over the unscrambled payload, bit 31 of each dword first, with no reflection and no final inversion.
- R8: The scrambler is a 16-bit shift register seeded with 0xF0F6. Each step outputs bit 15 and shifts left, taking in bit15^bit14^bit12^bit3. One 32-bit word is 32 steps, with the first output in bit 0. The register advances one word per data dword sent, including the CRC slot.
- R9: EOF (0xD5D5B57C, tx_isk=1) is sent for exactly one slot after the CRC slot, followed by WTRM.
- R10: In WTRM every slot carries WTRM (0x5858B57C, tx_isk=1). In the slot where rx_dword equals R_OK or R_ERR (0x5656B57C), done_valid=1, with done_ok=1 for R_OK and 0 for R_ERR. The next slot is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one dword per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pl_valid | input | 1 | Payload dword offered |
| pl_ready | output | 1 | Payload dword taken this slot |
| pl_data | input | 32 | Payload dword |
| pl_last | input | 1 | Offered dword is the final one of the payload |
| rx_dword | input | 32 | Dword received from the far end this slot |
| tx_dword | output | 32 | Dword sent to the PHY this slot |
| tx_isk | output | 1 | 1 when tx_dword is a primitive |
| done_valid | output | 1 | Verdict pulse in the closing WTRM slot |
| done_ok | output | 1 | Verdict: 1 for R_OK, 0 for R_ERR |

## Verification
The assertions take for granted a well-behaved payload source: pl_data and pl_last hold steady until they are taken, and the final dword carries pl_last. The stimulus follows this by presenting each payload dword with pl_last set only on the final index, and by keeping the same dword in place across HOLD and source-gap slots. The assertions also take for granted that the receiver sends HOLD only inside a frame and that a verdict follows WTRM. The stimulus sends R_RDY and verdict primitives only after a programmed number of slots in the matching states.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
    localparam int DW = 32;

    localparam logic [DW-1:0] PRIM_SYNC  = 32'hB5B5957C;
    localparam logic [DW-1:0] PRIM_XRDY  = 32'h5757B57C;
    localparam logic [DW-1:0] PRIM_RRDY  = 32'h4A4A957C;
    localparam logic [DW-1:0] PRIM_SOF   = 32'h3737B57C;
    localparam logic [DW-1:0] PRIM_EOF   = 32'hD5D5B57C;
    localparam logic [DW-1:0] PRIM_HOLD  = 32'hD5D5AA7C;
    localparam logic [DW-1:0] PRIM_HOLDA = 32'h9595AA7C;
    localparam logic [DW-1:0] PRIM_WTRM  = 32'h5858B57C;
    localparam logic [DW-1:0] PRIM_ROK   = 32'h3535B57C;
    localparam logic [DW-1:0] PRIM_RERR  = 32'h5656B57C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDY,
        ST_SOF,
        ST_DATA,
        ST_EOF,
        ST_WTRM
    } fr_state_t;
endpackage

// File: rtl/lnk_crc32.sv
module lnk_crc32 #(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C11DB7,
    parameter logic [W-1:0] SEED = 32'h52325032
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc
);
    logic [W-1:0] acc_q;

    function automatic logic [W-1:0] fold(input logic [W-1:0] c, input logic [W-1:0] d);
        logic [W-1:0] r;
        logic         fb;
        r = c;
        for (int i = W - 1; i >= 0; i--) begin
            fb = r[W-1] ^ d[i];
            r  = {r[W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n || init) acc_q <= SEED;
        else if (en)        acc_q <= fold(acc_q, din);
    end

    assign crc = acc_q;
endmodule

// File: rtl/lnk_scrambler.sv
module lnk_scrambler #(
    parameter int            SW   = 16,
    parameter int            OW   = 32,
    parameter logic [SW-1:0] SEED = 16'hF0F6,
    parameter logic [SW-1:0] TAPS = 16'hD008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          adv,
    output logic [OW-1:0] word
);
    logic [SW-1:0] st_q;
    logic [SW-1:0] st_nx;

    always_comb begin
        logic [SW-1:0] s;
        s    = st_q;
        word = '0;
        for (int j = 0; j < OW; j++) begin
            word[j] = s[SW-1];
            s       = {s[SW-2:0], ^(s & TAPS)};
        end
        st_nx = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init) st_q <= SEED;
        else if (adv)       st_q <= st_nx;
    end
endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
    import lnk_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pl_valid,
    input  logic [DW-1:0] pl_data,
    input  logic          pl_last,
    input  logic [DW-1:0] rx_dword,
    input  logic [DW-1:0] scr_word,
    input  logic [DW-1:0] crc_value,
    output logic          pl_ready,
    output logic [DW-1:0] tx_dword,
    output logic          tx_isk,
    output logic          done_valid,
    output logic          done_ok,
    output logic          crc_init,
    output logic          crc_en,
    output logic          scr_init,
    output logic          scr_adv
);
    fr_state_t state_q, state_nx;
    logic      crc_phase_q, crc_phase_nx;
    logic      rx_hold;

    assign rx_hold = (rx_dword == PRIM_HOLD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            crc_phase_q <= 1'b0;
        end else begin
            state_q     <= state_nx;
            crc_phase_q <= crc_phase_nx;
        end
    end

    always_comb begin
        state_nx     = state_q;
        crc_phase_nx = crc_phase_q;
        tx_dword     = PRIM_SYNC;
        tx_isk       = 1'b1;
        pl_ready     = 1'b0;
        done_valid   = 1'b0;
        done_ok      = 1'b0;
        crc_init     = 1'b0;
        crc_en       = 1'b0;
        scr_init     = 1'b0;
        scr_adv      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pl_valid) state_nx = ST_RDY;
            end
            ST_RDY: begin
                tx_dword = PRIM_XRDY;
                if (rx_dword == PRIM_RRDY) state_nx = ST_SOF;
            end
            ST_SOF: begin
                tx_dword     = PRIM_SOF;
                crc_init     = 1'b1;
                scr_init     = 1'b1;
                crc_phase_nx = 1'b0;
                state_nx     = ST_DATA;
            end
            ST_DATA: begin
                if (rx_hold) begin
                    tx_dword = PRIM_HOLDA;
                end else if (!crc_phase_q) begin
                    if (pl_valid) begin
                        tx_dword = pl_data ^ scr_word;
                        tx_isk   = 1'b0;
                        pl_ready = 1'b1;
                        crc_en   = 1'b1;
                        scr_adv  = 1'b1;
                        if (pl_last) crc_phase_nx = 1'b1;
                    end else begin
                        tx_dword = PRIM_HOLD;
                    end
                end else begin
                    tx_dword     = crc_value ^ scr_word;
                    tx_isk       = 1'b0;
                    scr_adv      = 1'b1;
                    crc_phase_nx = 1'b0;
                    state_nx     = ST_EOF;
                end
            end
            ST_EOF: begin
                tx_dword = PRIM_EOF;
                state_nx = ST_WTRM;
            end
            ST_WTRM: begin
                tx_dword = PRIM_WTRM;
                if (rx_dword == PRIM_ROK) begin
                    done_valid = 1'b1;
                    done_ok    = 1'b1;
                    state_nx   = ST_IDLE;
                end else if (rx_dword == PRIM_RERR) begin
                    done_valid = 1'b1;
                    state_nx   = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R3
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOF) |=> (state_q == ST_DATA));

    // R9
    eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOF) |=> (state_q == ST_WTRM));

    // R4
    ready_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> !tx_isk);

    // R10
    verdict_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (state_q == ST_IDLE));
endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
    import lnk_tx_pkg::*;
#(
    parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
    parameter logic [31:0] CRC_SEED = 32'h52325032,
    parameter logic [15:0] SCR_SEED = 16'hF0F6,
    parameter logic [15:0] SCR_TAPS = 16'hD008
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pl_valid,
    output logic        pl_ready,
    input  logic [31:0] pl_data,
    input  logic        pl_last,
    input  logic [31:0] rx_dword,
    output logic [31:0] tx_dword,
    output logic        tx_isk,
    output logic        done_valid,
    output logic        done_ok
);
    logic [DW-1:0] scr_word, crc_value;
    logic          crc_init, crc_en, scr_init, scr_adv;

    lnk_crc32 #(.W(DW), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .din(pl_data), .crc(crc_value)
    );

    lnk_scrambler #(.SW(16), .OW(DW), .SEED(SCR_SEED), .TAPS(SCR_TAPS)) u_scr (
        .clk(clk), .rst_n(rst_n), .init(scr_init), .adv(scr_adv), .word(scr_word)
    );

    lnk_tx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_data(pl_data),
        .pl_last(pl_last), .rx_dword(rx_dword), .scr_word(scr_word),
        .crc_value(crc_value), .pl_ready(pl_ready), .tx_dword(tx_dword),
        .tx_isk(tx_isk), .done_valid(done_valid), .done_ok(done_ok),
        .crc_init(crc_init), .crc_en(crc_en), .scr_init(scr_init), .scr_adv(scr_adv)
    );

    // R5
    holda_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_isk && tx_dword == PRIM_HOLDA) |=> ($stable(crc_value) && $stable(scr_word)));

    // R10
    verdict_in_wtrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (tx_isk && tx_dword == PRIM_WTRM));
endmodule

// File: tb/link_tx_framer_test.sv
module link_tx_framer_test;
    localparam logic [31:0] P_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] P_XRDY  = 32'h5757B57C;
    localparam logic [31:0] P_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] P_SOF   = 32'h3737B57C;
    localparam logic [31:0] P_EOF   = 32'hD5D5B57C;
    localparam logic [31:0] P_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] P_HOLDA = 32'h9595AA7C;
    localparam logic [31:0] P_WTRM  = 32'h5858B57C;
    localparam logic [31:0] P_ROK   = 32'h3535B57C;
    localparam logic [31:0] P_RERR  = 32'h5656B57C;
    localparam logic [31:0] P_RIP   = 32'h5555B57C;

    // {len[63:56], rdy_wait[55:52], wtrm_wait[51:48], err[47], pad, hold[31:16], gap[15:0]}
    localparam int NV = 6;
    localparam logic [63:0] VEC [NV] = '{
        {8'd1,  4'd0, 4'd0, 1'b0, 15'd0, 16'h0002, 16'h0000},
        {8'd4,  4'd3, 4'd2, 1'b0, 15'd0, 16'h0002, 16'h0000},
        {8'd6,  4'd1, 4'd1, 1'b1, 15'd0, 16'h0000, 16'h0005},
        {8'd8,  4'd0, 4'd3, 1'b0, 15'd0, 16'h0110, 16'h0048},
        {8'd3,  4'd2, 4'd0, 1'b1, 15'd0, 16'h000F, 16'h0030},
        {8'd16, 4'd0, 4'd0, 1'b0, 15'd0, 16'h8000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [31:0] pl_data = '0;
    logic        pl_last = 1'b0;
    logic [31:0] rx_dword = P_SYNC;
    logic [31:0] tx_dword;
    logic        tx_isk;
    logic        done_valid;
    logic        done_ok;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    link_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_ready(pl_ready),
        .pl_data(pl_data), .pl_last(pl_last), .rx_dword(rx_dword),
        .tx_dword(tx_dword), .tx_isk(tx_isk), .done_valid(done_valid), .done_ok(done_ok)
    );

    function automatic logic [31:0] m_crc(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            logic b = r[31] ^ d[i];
            r = r << 1;
            if (b) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic [31:0] m_scr_word(input logic [15:0] s0);
        logic [15:0] s = s0;
        logic [31:0] w = '0;
        for (int j = 0; j < 32; j++) begin
            w[j] = s[15];
            s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
        end
        return w;
    endfunction

    function automatic logic [15:0] m_scr_next(input logic [15:0] s0);
        logic [15:0] s = s0;
        for (int j = 0; j < 32; j++) s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
        return s;
    endfunction

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%08h expected=%08h", rq, what, act, exp);
        end
    endtask

    task automatic slot(input string rq, input logic [31:0] ed, input logic ei,
                        input logic er, input logic edv, input logic eok);
        #2;
        check(rq, "tx_dword", tx_dword, ed);
        check(rq, "tx_isk", {31'd0, tx_isk}, {31'd0, ei});
        check(rq, "pl_ready", {31'd0, pl_ready}, {31'd0, er});
        check(rq, "done_valid", {31'd0, done_valid}, {31'd0, edv});
        if (edv) check(rq, "done_ok", {31'd0, done_ok}, {31'd0, eok});
        @(posedge clk);
    endtask

    task automatic run_frame(input int fr, input logic [63:0] v);
        int len = int'(v[63:56]);
        int rdyw = int'(v[55:52]);
        int wtw = int'(v[51:48]);
        logic err = v[47];
        logic [15:0] hm = v[31:16];
        logic [15:0] gm = v[15:0];
        logic [31:0] crc;
        logic [15:0] scr;
        int idx = 0;
        int sl = 0;
        // IDLE slot with payload offered (R1)
        @(negedge clk);
        pl_valid = 1'b1; pl_data = {fr[7:0], 8'h3C, 16'd0}; pl_last = (len == 1); rx_dword = P_SYNC;
        slot("R1", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k <= rdyw; k++) begin
            @(negedge clk);
            rx_dword = (k == rdyw) ? P_RRDY : P_SYNC;
            slot("R2", P_XRDY, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk);
        rx_dword = P_RIP;
        slot("R3", P_SOF, 1'b1, 1'b0, 1'b0, 1'b0);
        crc = 32'h52325032;
        scr = 16'hF0F6;
        while (idx <= len) begin
            logic h = hm[sl % 16];
            logic g = gm[sl % 16];
            logic [31:0] d = {fr[7:0], 8'h3C, 16'(idx)} ^ (32'h01010101 * idx);
            @(negedge clk);
            rx_dword = h ? P_HOLD : P_RIP;
            pl_data  = d;
            pl_last  = (idx == len - 1);
            pl_valid = (idx < len) && !g;
            if (h) begin
                slot("R5", P_HOLDA, 1'b1, 1'b0, 1'b0, 1'b0);
            end else if (idx < len) begin
                if (g) slot("R6", P_HOLD, 1'b1, 1'b0, 1'b0, 1'b0);
                else begin
                    slot("R4", d ^ m_scr_word(scr), 1'b0, 1'b1, 1'b0, 1'b0);
                    crc = m_crc(crc, d);
                    scr = m_scr_next(scr);
                    idx++;
                end
            end else begin
                // R8 scrambler continues into CRC slot
                slot("R7", crc ^ m_scr_word(scr), 1'b0, 1'b0, 1'b0, 1'b0);
                idx++;
            end
            sl++;
        end
        @(negedge clk);
        pl_valid = 1'b0; pl_last = 1'b0; rx_dword = P_RIP;
        slot("R9", P_EOF, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k <= wtw; k++) begin
            @(negedge clk);
            rx_dword = (k == wtw) ? (err ? P_RERR : P_ROK) : P_RIP;
            slot("R10", P_WTRM, 1'b1, 1'b0, (k == wtw), !err);
        end
        @(negedge clk);
        rx_dword = P_SYNC;
        slot("R10", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        pl_valid = 1'b1; rx_dword = P_RRDY;
        slot("R1", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; pl_valid = 1'b0;
        for (int i = 0; i < NV; i++) run_frame(i + 1, VEC[i]);
        // R1 idle ignores R_RDY / R_OK / HOLD with no payload
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            pl_valid = 1'b0;
            rx_dword = (k == 0) ? P_RRDY : (k == 1) ? P_ROK : P_HOLD;
            slot("R1", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        // R5 held CRC slot and R10 long wait with error verdict
        run_frame(9, {8'd2, 4'd5, 4'd6, 1'b1, 15'd0, 16'h000C, 16'h0000});
        // R3 reseed: identical payload twice yields identical dwords
        run_frame(9, {8'd2, 4'd0, 4'd0, 1'b0, 15'd0, 16'h0000, 16'h0000});
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule